// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target on a two-wire serial management bus of the SMBus/I2C kind. It holds a small file of byte-wide registers. A host reaches them through indexed block transfers. The clock and data lines are oversampled on a fast system clock. The target pulls the data line low through an output-enable pin and never drives it high. It recognises start, repeated-start and stop conditions and answers one fixed 7-bit device address.

**Block write.** The host sends a starting index, then a byte count, then that many data bytes. The data bytes land at consecutive register locations.

**Block read.** The host first writes only the index. It then issues a repeated start with the read direction bit set. The target answers with a byte count taken from a programmable register, followed by data bytes starting at the index. The host ends the read by refusing the last byte.

The whole register array is mirrored on a parallel debug output. Surrounding logic can use the register values directly from there.

The bus pins are control-style signals with no valid/ready handshake. The bus itself has no back-pressure in this design: the target never holds the clock low, so the host's clock sets the pace. Each byte must be fully clocked before it takes effect.

Top module: `smb_blkreg_target`

## Requirements
- R1: After reset, `sda_oe` is 0. Every register reads 0x00, except the read-count register at index `CNT_IDX` (default 8), which holds `CNT_RST` (default 0x04).
- R2: The address byte is acknowledged (SDA held low during the ninth clock) only when its upper 7 bits equal `DEV_ADDR`. On any other address the target does not acknowledge and leaves SDA released until the next start.
- R3: In a write transfer, the first byte after the address is the index N and the second is the count X. The next X data bytes are each acknowledged and stored at N, N+1, … N+X-1.
- R4: A data byte that arrives after the X counted bytes is not acknowledged and not stored. The target stays off the bus until the next start.
- R5: The index advances to 0 after index `NUM_REGS`-1, on both writes and reads. A write to an index of `NUM_REGS` or above is acknowledged but changes no register.
- R6: After a repeated start with the read bit (address LSB = 1), the target acknowledges. It then sends one count byte, followed by register bytes starting at the index most recently written, MSB first.
- R7: The count byte sent on a read equals the current content of register `CNT_IDX`. A host write to that register changes the count returned by later reads.
- R8: When the host does not acknowledge a byte the target sent, the target releases SDA and sends nothing more until the next start.
- R9: A start or stop condition in the middle of a byte abandons the transfer. The partial byte is not stored, and bytes that were fully received and acknowledged remain stored.
- R10: The target changes `sda_oe` only while SCL is low. It releases its acknowledge after the ninth falling edge of SCL in a byte.
- R11: A read from an index of `NUM_REGS` or above returns 0x00.
- R12: `dbg_regs[8*i +: 8]` shows register i. It changes only in the cycle after a data byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dbg_regs | output | 8*NUM_REGS | Flat copy of the register file, register i in bits 8*i+7 down to 8*i |

## Verification
The checks on `sda_oe` assume that every high and low phase of SCL lasts well beyond the three-cycle delay of the synchronizer and edge detector. They also assume that the host changes SDA while SCL is high only to form a start or a stop, and never while the target is pulling the line low. The stimulus holds every SCL phase for at least ten system clocks. It moves the host's data only in the low phase, and it only issues starts and stops after the target has released the line. Given these inputs, a change of the output enable can only fall inside an SCL low phase.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q      <= '1;
      q_prev <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int         NUM_REGS = 16,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] CNT_RST  = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            cnt_val,
  output logic [8*NUM_REGS-1:0] flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_V = (g == CNT_IDX) ? CNT_RST : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= RST_V;
      else if (wr_en && wr_idx == 8'(g))   q <= wr_data;
    end
    assign flat[8*g +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 8'(i)) rd_data = flat[8*i +: 8];
  end

  assign cnt_val = flat[8*CNT_IDX +: 8];
endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine
  import smb_blk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6C,
  parameter int         NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       scl_p,
  input  logic       sda_s,
  input  logic       sda_p,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic       drv,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output logic       quiet
);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  phase_e     ph_q;
  logic [3:0] bit_q;
  logic [7:0] rx_q, tx_q, left_q, ptr_q;
  logic       hack_q, first_q;

  wire scl_hi   = scl_s & scl_p;
  wire start_ev = scl_hi & sda_p & ~sda_s;
  wire stop_ev  = scl_hi & ~sda_p & sda_s;
  wire rise     = scl_s & ~scl_p;
  wire fall     = ~scl_s & scl_p;
  wire active   = (ph_q != PH_IDLE) && (ph_q != PH_IGNORE);
  wire [7:0] ptr_nx = (ptr_q == LAST) ? 8'h00 : ptr_q + 8'h01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      hack_q  <= 1'b0;
      first_q <= 1'b0;
      drv     <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        ph_q  <= PH_ADDR;
        bit_q <= '0;
        drv   <= 1'b0;
      end else if (stop_ev) begin
        ph_q  <= PH_IDLE;
        bit_q <= '0;
        drv   <= 1'b0;
      end else if (active && rise) begin
        if (bit_q < 4'd8 && ph_q != PH_RDATA) rx_q <= {rx_q[6:0], sda_s};
        if (bit_q == 4'd8 && ph_q == PH_RDATA) hack_q <= ~sda_s;
        bit_q <= bit_q + 4'd1;
      end else if (active && fall) begin
        if (ph_q == PH_RDATA) begin
          if (bit_q >= 4'd1 && bit_q <= 4'd7) begin
            tx_q <= {tx_q[6:0], 1'b0};
            drv  <= ~tx_q[6];
          end else if (bit_q == 4'd8) begin
            drv <= 1'b0;
          end else if (bit_q == 4'd9) begin
            bit_q <= '0;
            if (!hack_q) begin
              ph_q <= PH_IGNORE;
              drv  <= 1'b0;
            end else if (first_q) begin
              first_q <= 1'b0;
              tx_q    <= cnt_val;
              drv     <= ~cnt_val[7];
            end else begin
              tx_q  <= rd_data;
              drv   <= ~rd_data[7];
              ptr_q <= ptr_nx;
            end
          end
        end else if (bit_q == 4'd8) begin
          unique case (ph_q)
            PH_ADDR: begin
              if (rx_q[7:1] == DEV_ADDR) begin
                drv     <= 1'b1;
                ph_q    <= rx_q[0] ? PH_RDATA : PH_INDEX;
                first_q <= 1'b1;
              end else begin
                ph_q <= PH_IGNORE;
              end
            end
            PH_INDEX: begin
              ptr_q <= rx_q;
              drv   <= 1'b1;
              ph_q  <= PH_COUNT;
            end
            PH_COUNT: begin
              left_q <= rx_q;
              drv    <= 1'b1;
              ph_q   <= PH_WDATA;
            end
            PH_WDATA: begin
              if (left_q != 8'h00) begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr_q;
                wr_data <= rx_q;
                ptr_q   <= ptr_nx;
                left_q  <= left_q - 8'h01;
                drv     <= 1'b1;
              end else begin
                ph_q <= PH_IGNORE;
              end
            end
            default: ph_q <= PH_IGNORE;
          endcase
        end else if (bit_q == 4'd9) begin
          drv   <= 1'b0;
          bit_q <= '0;
        end
      end
    end
  end

  assign rd_idx = ptr_q;
  assign quiet  = !active;
endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h6C,
  parameter int         NUM_REGS = 16,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] CNT_RST  = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] dbg_regs
);
  logic [1:0] ln_s, ln_p;
  logic       wr_en, quiet;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val;

  smb_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(ln_s), .q_prev(ln_p)
  );

  smb_blk_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_s(ln_s[1]), .scl_p(ln_p[1]), .sda_s(ln_s[0]), .sda_p(ln_p[0]),
    .rd_data(rd_data), .cnt_val(cnt_val), .drv(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .quiet(quiet)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt_val(cnt_val), .flat(dbg_regs)
  );
endmodule

// File: rtl/smb_blkreg_checker.sv
module smb_blkreg_checker #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [8*NUM_REGS-1:0] dbg_regs,
  input logic                  wr_en,
  input logic [7:0]            wr_idx,
  input logic [7:0]            rd_idx,
  input logic                  quiet
);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_quiet_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe);

  p_one_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_index_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == LAST) |-> rd_idx == 8'h00);

  p_dbg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dbg_regs));
endmodule

bind smb_blkreg_target smb_blkreg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .dbg_regs(dbg_regs),
  .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .quiet(quiet)
);

// File: tb/smb_blkreg_target_bench.sv
module smb_blkreg_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int NREG       = 16;
  localparam int WD_LIMIT   = 190000;
  localparam logic [7:0] AW = 8'hD8;
  localparam logic [7:0] AR = 8'hD9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic [8*NREG-1:0] dbg_regs;
  wire sda_bus = host_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_blkreg_target u_smb_blkreg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .dbg_regs(dbg_regs)
  );

  function automatic logic [7:0] rg(int i);
    return dbg_regs[8*i +: 8];
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    host_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    host_sda = b; tick(Q); scl = 1'b1; tick(Q);
    s = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic open_write(input logic [7:0] idx, input logic [7:0] cnt, string req);
    logic a;
    bus_start;
    wr_byte(AW, a); chk({req, " addr ack"}, a, 1);
    wr_byte(idx, a); chk({req, " index ack"}, a, 1);
    wr_byte(cnt, a); chk({req, " count ack"}, a, 1);
  endtask

  task automatic open_read(input logic [7:0] idx, string req);
    logic a;
    bus_start;
    wr_byte(AW, a); chk({req, " addr W ack"}, a, 1);
    wr_byte(idx, a); chk({req, " index ack"}, a, 1);
    bus_start;
    wr_byte(AR, a); chk({req, " addr R ack"}, a, 1);
  endtask

  task automatic t_reset;
    chk("R1 oe", sda_oe, 0);
    chk("R1 reg0", rg(0), 8'h00);
    chk("R1 count reg", rg(8), 8'h04);
    chk("R1 reg15", rg(15), 8'h00);
  endtask

  task automatic t_block_write;
    logic a;
    bus_start;
    wr_byte(AW, a);
    chk("R2 own addr ack", a, 1);
    chk("R10 ack released after 9th fall", sda_oe, 0);
    wr_byte(8'h02, a); chk("R3 index ack", a, 1);
    wr_byte(8'h03, a); chk("R3 count ack", a, 1);
    wr_byte(8'hA1, a); chk("R3 d0 ack", a, 1);
    wr_byte(8'hB2, a); chk("R3 d1 ack", a, 1);
    wr_byte(8'hC3, a); chk("R3 d2 ack", a, 1);
    bus_stop;
    chk("R3 reg2", rg(2), 8'hA1);
    chk("R3 reg3", rg(3), 8'hB2);
    chk("R12 reg4", rg(4), 8'hC3);
    chk("R3 reg5 untouched", rg(5), 8'h00);
  endtask

  task automatic t_excess;
    logic a;
    open_write(8'h0A, 8'h01, "R4");
    wr_byte(8'h55, a); chk("R4 counted byte ack", a, 1);
    wr_byte(8'h66, a); chk("R4 extra byte nack", a, 0);
    bus_stop;
    chk("R4 reg10", rg(10), 8'h55);
    chk("R4 reg11 not stored", rg(11), 8'h00);
  endtask

  task automatic t_wrap_write;
    logic a;
    logic [8*NREG-1:0] snap;
    open_write(8'h0F, 8'h03, "R5");
    wr_byte(8'h11, a); chk("R5 d0 ack", a, 1);
    wr_byte(8'h22, a); chk("R5 d1 ack", a, 1);
    wr_byte(8'h33, a); chk("R5 d2 ack", a, 1);
    bus_stop;
    chk("R5 reg15", rg(15), 8'h11);
    chk("R5 wrap reg0", rg(0), 8'h22);
    chk("R5 wrap reg1", rg(1), 8'h33);
    snap = dbg_regs;
    open_write(8'h14, 8'h01, "R5 high");
    wr_byte(8'h77, a); chk("R5 out-of-range ack", a, 1);
    bus_stop;
    chk("R5 out-of-range discarded", dbg_regs, snap);
  endtask

  task automatic t_bad_addr;
    logic a;
    logic [8*NREG-1:0] snap;
    snap = dbg_regs;
    bus_start;
    wr_byte(8'hA0, a); chk("R2 foreign addr nack", a, 0);
    wr_byte(8'h00, a); chk("R2 silent after foreign addr", a, 0);
    wr_byte(8'h01, a); chk("R2 still silent", a, 0);
    bus_stop;
    chk("R2 regs unchanged", dbg_regs, snap);
  endtask

  task automatic t_read;
    logic a;
    logic [7:0] d;
    logic [8*NREG-1:0] snap;
    snap = dbg_regs;
    open_read(8'h02, "R6");
    rd_byte(1, d); chk("R7 count byte reset value", d, 8'h04);
    rd_byte(1, d); chk("R6 data idx2", d, 8'hA1);
    rd_byte(1, d); chk("R6 data idx3", d, 8'hB2);
    rd_byte(0, d); chk("R6 data idx4", d, 8'hC3);
    chk("R8 released after host nack", sda_oe, 0);
    rd_byte(0, d); chk("R8 no further bytes", d, 8'hFF);
    bus_stop;
    chk("R12 read leaves regs", dbg_regs, snap);
    open_write(8'h08, 8'h01, "R7");
    wr_byte(8'h02, a); chk("R7 count write ack", a, 1);
    bus_stop;
    open_read(8'h03, "R7");
    rd_byte(1, d); chk("R7 programmed count", d, 8'h02);
    rd_byte(1, d); chk("R6 data idx3 again", d, 8'hB2);
    rd_byte(0, d); chk("R6 data idx4 again", d, 8'hC3);
    bus_stop;
  endtask

  task automatic t_read_wrap;
    logic [7:0] d;
    open_read(8'h0F, "R5 read");
    rd_byte(1, d); chk("R7 count", d, 8'h02);
    rd_byte(1, d); chk("R5 read idx15", d, 8'h11);
    rd_byte(0, d); chk("R5 read wraps to idx0", d, 8'h22);
    bus_stop;
    open_read(8'h1E, "R11");
    rd_byte(1, d); chk("R11 count", d, 8'h02);
    rd_byte(1, d); chk("R11 unimplemented reads zero", d, 8'h00);
    rd_byte(0, d); chk("R11 unimplemented next", d, 8'h00);
    bus_stop;
  endtask

  task automatic t_abort;
    logic a, s;
    open_write(8'h05, 8'h03, "R9");
    wr_byte(8'h9A, a); chk("R9 first byte ack", a, 1);
    for (int i = 0; i < 4; i++) clk_bit(i[0], s);
    bus_stop;
    chk("R9 full byte kept", rg(5), 8'h9A);
    chk("R9 partial byte dropped", rg(6), 8'h00);
    open_write(8'h06, 8'h02, "R9 rs");
    for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
    bus_start;
    wr_byte(AW, a); chk("R9 restart addr ack", a, 1);
    wr_byte(8'h07, a); chk("R9 restart index ack", a, 1);
    wr_byte(8'h01, a); chk("R9 restart count ack", a, 1);
    wr_byte(8'h3C, a); chk("R9 restart data ack", a, 1);
    bus_stop;
    chk("R9 reg6 untouched", rg(6), 8'h00);
    chk("R9 reg7 after restart", rg(7), 8'h3C);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_block_write;
    t_excess;
    t_wrap_write;
    t_bad_addr;
    t_read;
    t_read_wrap;
    t_abort;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule